// File: doc/BRIEF.md
# Tagged Associative Translation Buffer

This block caches recent virtual-to-physical page translations. A lookup presents a virtual page number; the block compares it, together with the current address-space tag, against every valid entry at once and reports one cycle later whether it found a match and which physical frame the match holds. A miss raises a one-cycle refill request. The surrounding logic then walks the page table and installs the resulting page/frame pair through the fill port.

Each entry holds a page number, a frame number, an address-space tag, a valid bit and a pinned bit. When a fill arrives, the lowest-numbered free entry is used. If no entry is free, the unpinned entry used least recently (by hit or by fill) is replaced. Pinned entries are never replaced and survive a flush. The flush clears every unpinned entry, which is what a context switch needs when tag matching is switched off. If every entry is pinned, a fill is dropped and an error pulse is raised.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is invalid: a lookup misses, and `lookup_done`, `lookup_hit`, `refill_req`, `fill_err` are 0 and `lookup_pfn` is 0 until a request arrives.
- R2: A lookup that matches a valid entry sets `lookup_done` and `lookup_hit` in the cycle after `lookup_valid` and returns the stored frame on `lookup_pfn`.
- R3: A lookup with no match sets `lookup_done` with `lookup_hit`=0, `lookup_pfn`=0 and `refill_req`=1 for that one cycle; `refill_req` is 0 in every other cycle.
- R4: With `asid_match_en`=1 a hit also needs the entry tag to equal `cur_asid`; with `asid_match_en`=0 the tag is ignored.
- R5: A fill while some entry is invalid evicts no valid entry.
- R6: A fill when every entry is valid replaces the valid unpinned entry whose last hit or fill is oldest.
- R7: An entry installed with `fill_pin`=1 is never replaced by a later fill.
- R8: `flush` invalidates every unpinned entry and keeps every pinned entry.
- R9: A fill when every entry is valid and pinned is dropped, and `fill_err` is 1 in the cycle after `fill_valid` only.
- R10: A lookup presented in the same cycle as a fill or a flush sees the entries as they were before that fill or flush.
- R11: When `flush` and `fill_valid` are high in the same cycle, the flush is applied and the fill is dropped without raising `fill_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| asid_match_en | input | 1 | 1: a hit also needs the tags to be equal |
| cur_asid | input | ASID_W | Address-space tag of the current lookup |
| lookup_valid | input | 1 | Lookup request |
| lookup_vpn | input | VPN_W | Virtual page number to translate |
| lookup_done | output | 1 | Result valid, one cycle after the request |
| lookup_hit | output | 1 | Translation found |
| lookup_pfn | output | PFN_W | Frame number on a hit, else 0 |
| refill_req | output | 1 | Miss pulse asking for a refill |
| fill_valid | input | 1 | Install request |
| fill_vpn | input | VPN_W | Page number to install |
| fill_pfn | input | PFN_W | Frame number to install |
| fill_asid | input | ASID_W | Address-space tag to install |
| fill_pin | input | 1 | 1: installed entry is pinned |
| flush | input | 1 | Invalidate all unpinned entries |
| fill_err | output | 1 | Fill dropped because every entry is pinned |

## Verification
A corrupted recency ranking shows only at the next fill into a full buffer: the wrong translation disappears, and the bench sees it on the first later lookup of the page that should have survived. A lost valid or pinned bit shows as a miss on the next lookup of that page. A stale entry after a flush shows as a hit one cycle after a lookup that should miss. The bench therefore follows each fill and flush with lookups of every page it has installed, so that any divergence is visible within a few cycles.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;

  // Source of the recency update applied in a cycle.
  typedef enum logic [1:0] {
    TOUCH_NONE = 2'd0,
    TOUCH_HIT  = 2'd1,
    TOUCH_FILL = 2'd2
  } tlb_touch_e;

endpackage

// File: rtl/tlb_match.sv
`timescale 1ns/1ps
module tlb_match #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]             ent_valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
  input  logic [ENTRIES-1:0][PFN_W-1:0]  ent_pfn,
  input  logic [ENTRIES-1:0][ASID_W-1:0] ent_asid,
  input  logic [VPN_W-1:0]               key_vpn,
  input  logic [ASID_W-1:0]              key_asid,
  input  logic                           asid_en,
  output logic                           hit,
  output logic [IDX_W-1:0]               hit_idx,
  output logic [PFN_W-1:0]               hit_pfn
);

  logic [ENTRIES-1:0] match_vec;

  // One comparator per entry.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = ent_valid[g] && (ent_vpn[g] == key_vpn) &&
                          (!asid_en || (ent_asid[g] == key_asid));
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    hit_pfn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) begin
        hit_pfn = hit_pfn | ent_pfn[i];
        if (!hit) begin
          hit     = 1'b1;
          hit_idx = IDX_W'(i);
        end
      end
    end
  end

endmodule

// File: rtl/tlb_victim.sv
`timescale 1ns/1ps
module tlb_victim #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]            ent_valid,
  input  logic [ENTRIES-1:0]            ent_pin,
  input  logic [ENTRIES-1:0][IDX_W-1:0] ent_age,
  output logic                          vic_ok,
  output logic [IDX_W-1:0]              vic_idx
);

  logic             free_found;
  logic [IDX_W-1:0] free_idx;
  logic             lru_found;
  logic [IDX_W-1:0] lru_idx;
  logic [IDX_W-1:0] lru_age;

  // Lowest-numbered invalid entry.
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!ent_valid[i] && !free_found) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  // Oldest valid unpinned entry; ages are a permutation, so no ties.
  always_comb begin
    lru_found = 1'b0;
    lru_idx   = '0;
    lru_age   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ent_valid[i] && !ent_pin[i] && (!lru_found || (ent_age[i] > lru_age))) begin
        lru_found = 1'b1;
        lru_idx   = IDX_W'(i);
        lru_age   = ent_age[i];
      end
    end
  end

  assign vic_ok  = free_found || lru_found;
  assign vic_idx = free_found ? free_idx : lru_idx;

endmodule

// File: rtl/tlb_age.sv
`timescale 1ns/1ps
module tlb_age #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          touch_en,
  input  logic [IDX_W-1:0]              touch_idx,
  output logic [ENTRIES-1:0][IDX_W-1:0] ages
);

  logic [ENTRIES-1:0][IDX_W-1:0] age_q;
  logic [ENTRIES-1:0][IDX_W-1:0] age_d;
  logic [IDX_W-1:0]              touch_age;

  assign touch_age = age_q[touch_idx];

  // Touched entry becomes rank 0; everything younger moves back one rank.
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      age_d[i] = age_q[i];
      if (IDX_W'(i) == touch_idx) begin
        age_d[i] = '0;
      end else if (age_q[i] < touch_age) begin
        age_d[i] = age_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        age_q[i] <= IDX_W'(i);
      end
    end else if (touch_en) begin
      age_q <= age_d;
    end
  end

  assign ages = age_q;

endmodule

// File: rtl/tlb_xlate.sv
`timescale 1ns/1ps
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              asid_match_en,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              lookup_valid,
  input  logic [VPN_W-1:0]  lookup_vpn,
  output logic              lookup_done,
  output logic              lookup_hit,
  output logic [PFN_W-1:0]  lookup_pfn,
  output logic              refill_req,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic              fill_pin,
  input  logic              flush,
  output logic              fill_err
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // Entry storage.
  logic [ENTRIES-1:0]             v_q, v_d;
  logic [ENTRIES-1:0]             pin_q, pin_d;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_q;

  logic                          hit;
  logic [IDX_W-1:0]              hit_idx;
  logic [PFN_W-1:0]              hit_pfn;
  logic                          vic_ok;
  logic [IDX_W-1:0]              vic_idx;
  logic [ENTRIES-1:0][IDX_W-1:0] ages;
  logic                          fill_go;
  tlb_touch_e                    touch_sel;
  logic                          touch_en;
  logic [IDX_W-1:0]              touch_idx;

  tlb_match #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)
  ) u_match (
    .ent_valid(v_q),
    .ent_vpn  (vpn_q),
    .ent_pfn  (pfn_q),
    .ent_asid (asid_q),
    .key_vpn  (lookup_vpn),
    .key_asid (cur_asid),
    .asid_en  (asid_match_en),
    .hit      (hit),
    .hit_idx  (hit_idx),
    .hit_pfn  (hit_pfn)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .ent_valid(v_q),
    .ent_pin  (pin_q),
    .ent_age  (ages),
    .vic_ok   (vic_ok),
    .vic_idx  (vic_idx)
  );

  // Flush wins over a fill in the same cycle.
  assign fill_go = fill_valid && !flush && vic_ok;

  // A fill's recency update wins over a hit's in the same cycle.
  always_comb begin
    touch_sel = TOUCH_NONE;
    if (fill_go)                  touch_sel = TOUCH_FILL;
    else if (lookup_valid && hit) touch_sel = TOUCH_HIT;
  end
  assign touch_en  = (touch_sel != TOUCH_NONE);
  assign touch_idx = (touch_sel == TOUCH_FILL) ? vic_idx : hit_idx;

  tlb_age #(.ENTRIES(ENTRIES)) u_age (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .touch_en (touch_en),
    .touch_idx(touch_idx),
    .ages     (ages)
  );

  // Valid / pinned next state.
  always_comb begin
    v_d   = v_q;
    pin_d = pin_q;
    if (flush) begin
      v_d = v_q & pin_q;
    end else if (fill_go) begin
      v_d[vic_idx]   = 1'b1;
      pin_d[vic_idx] = fill_pin;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      v_q   <= '0;
      pin_q <= '0;
    end else if (flush || fill_go) begin
      v_q   <= v_d;
      pin_q <= pin_d;
    end
  end

  // Payload, written only on an accepted fill.
  always_ff @(posedge clk) begin
    if (fill_go) begin
      vpn_q[vic_idx]  <= fill_vpn;
      pfn_q[vic_idx]  <= fill_pfn;
      asid_q[vic_idx] <= fill_asid;
    end
  end

  // Registered results.
  logic             done_d, hit_d, refill_d, err_d;
  logic [PFN_W-1:0] pfn_d;

  always_comb begin
    done_d   = lookup_valid;
    hit_d    = lookup_valid && hit;
    refill_d = lookup_valid && !hit;
    pfn_d    = (lookup_valid && hit) ? hit_pfn : '0;
    err_d    = fill_valid && !flush && !vic_ok;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      lookup_done <= 1'b0;
      lookup_hit  <= 1'b0;
      refill_req  <= 1'b0;
      lookup_pfn  <= '0;
      fill_err    <= 1'b0;
    end else begin
      lookup_done <= done_d;
      lookup_hit  <= hit_d;
      refill_req  <= refill_d;
      lookup_pfn  <= pfn_d;
      fill_err    <= err_d;
    end
  end

endmodule

// File: rtl/tlb_xlate_chk.sv
`timescale 1ns/1ps
module tlb_xlate_chk #(
  parameter int ENTRIES = 64,
  parameter int PFN_W   = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lookup_valid,
  input logic               lookup_done,
  input logic               lookup_hit,
  input logic [PFN_W-1:0]   lookup_pfn,
  input logic               refill_req,
  input logic               fill_valid,
  input logic               flush,
  input logic               fill_err,
  input logic [ENTRIES-1:0] v_q,
  input logic [ENTRIES-1:0] pin_q
);

  p_done_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_valid |=> lookup_done);

  p_miss_asks_refill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_done && !lookup_hit) |-> refill_req);

  p_refill_only_on_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req |-> (lookup_done && !lookup_hit));

  p_miss_pfn_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_hit |-> (lookup_pfn == '0));

  p_pinned_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(v_q & pin_q)) |=> ((v_q & $past(v_q & pin_q)) == $past(v_q & pin_q)));

  p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ((v_q & ~$past(pin_q)) == '0));

  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_err |-> ($past(fill_valid) && !$past(flush) && $past(&(v_q & pin_q))));

endmodule

bind tlb_xlate tlb_xlate_chk #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .lookup_valid(lookup_valid),
  .lookup_done (lookup_done),
  .lookup_hit  (lookup_hit),
  .lookup_pfn  (lookup_pfn),
  .refill_req  (refill_req),
  .fill_valid  (fill_valid),
  .flush       (flush),
  .fill_err    (fill_err),
  .v_q         (v_q),
  .pin_q       (pin_q)
);

// File: tb/test_tlb_xlate.sv
`timescale 1ns/1ps
module test_tlb_xlate;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        asid_match_en;
  logic [7:0]  cur_asid;
  logic        lookup_valid;
  logic [19:0] lookup_vpn;
  logic        lookup_done;
  logic        lookup_hit;
  logic [19:0] lookup_pfn;
  logic        refill_req;
  logic        fill_valid;
  logic [19:0] fill_vpn;
  logic [19:0] fill_pfn;
  logic [7:0]  fill_asid;
  logic        fill_pin;
  logic        flush;
  logic        fill_err;

  always #4 clk = ~clk;

  tlb_xlate #(.ENTRIES(N), .VPN_W(20), .PFN_W(20), .ASID_W(8)) i_tlb_xlate (
    .clk(clk), .rst_n(rst_n), .asid_match_en(asid_match_en), .cur_asid(cur_asid),
    .lookup_valid(lookup_valid), .lookup_vpn(lookup_vpn), .lookup_done(lookup_done),
    .lookup_hit(lookup_hit), .lookup_pfn(lookup_pfn), .refill_req(refill_req),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_asid(fill_asid), .fill_pin(fill_pin), .flush(flush), .fill_err(fill_err)
  );

  int n_chk = 0;
  int n_err = 0;

  typedef struct {
    bit          hit;
    logic [19:0] pfn;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  // Reference model, built from the requirements.
  bit          m_valid[N];
  bit          m_pin[N];
  logic [19:0] m_vpn[N];
  logic [19:0] m_pfn[N];
  logic [7:0]  m_asid[N];
  int          m_stamp[N];
  int          tick = 0;

  function automatic int m_find(logic [19:0] vpn, logic [7:0] asid, bit en);
    for (int i = 0; i < N; i++)
      if (m_valid[i] && m_vpn[i] == vpn && (!en || m_asid[i] == asid)) return i;
    return -1;
  endfunction

  function automatic int m_victim();
    int best = -1;
    for (int i = 0; i < N; i++) if (!m_valid[i]) return i;
    for (int i = 0; i < N; i++)
      if (!m_pin[i] && (best < 0 || m_stamp[i] < m_stamp[best])) best = i;
    return best;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: one operation per call, then one idle cycle.
  task automatic op(bit lk, logic [19:0] vpn, logic [7:0] asid, bit en,
                    bit fl, bit fv, logic [19:0] fvpn, logic [19:0] fpfn,
                    logic [7:0] fasid, bit fpin, string req);
    int  idx;
    int  vic;
    bit  go;
    bit  exp_err;
    exp_t e;
    @(negedge clk);
    lookup_valid = lk; lookup_vpn = vpn; cur_asid = asid; asid_match_en = en;
    flush = fl; fill_valid = fv; fill_vpn = fvpn; fill_pfn = fpfn;
    fill_asid = fasid; fill_pin = fpin;
    idx = -1; go = 0; exp_err = 0;
    if (lk) begin
      idx   = m_find(vpn, asid, en);
      e.hit = (idx >= 0);
      e.pfn = (idx >= 0) ? m_pfn[idx] : 20'h0;
      e.req = req;
      exp_q.push_back(e);
    end
    if (fl) begin
      for (int i = 0; i < N; i++) if (!m_pin[i]) m_valid[i] = 0;
    end else if (fv) begin
      vic = m_victim();
      if (vic < 0) exp_err = 1;
      else begin
        go = 1;
        m_valid[vic] = 1; m_pin[vic] = fpin; m_vpn[vic] = fvpn;
        m_pfn[vic] = fpfn; m_asid[vic] = fasid; m_stamp[vic] = ++tick;
      end
    end
    if (lk && idx >= 0 && !go) m_stamp[idx] = ++tick;
    @(negedge clk);
    lookup_valid = 0; fill_valid = 0; flush = 0;
    if (fv) check(fill_err == exp_err, req, "fill_err", fill_err, exp_err);
  endtask

  task automatic look(logic [19:0] vpn, logic [7:0] asid, bit en, string req);
    op(1, vpn, asid, en, 0, 0, 0, 0, 0, 0, req);
  endtask

  task automatic fill(logic [19:0] vpn, logic [19:0] pfn, logic [7:0] asid, bit pin, string req);
    op(0, 0, 0, 1, 0, 1, vpn, pfn, asid, pin, req);
  endtask

  // Monitor: pops one expectation per result.
  always @(negedge clk) begin
    if (lookup_done) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R2: unexpected lookup_done actual=1 expected=0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(lookup_hit == e.hit, e.req, "lookup_hit", lookup_hit, e.hit);
        check(lookup_pfn == e.pfn, e.req, "lookup_pfn", lookup_pfn, e.pfn);
        check(refill_req == !e.hit, (e.hit ? e.req : "R3"), "refill_req", refill_req, !e.hit);
      end
    end else if (rst_n && refill_req) begin
      n_chk++; n_err++;
      $display("FAIL R3: refill_req without result actual=1 expected=0");
    end
  end

  initial begin
    #(200000 * 8);
    n_err++;
    $display("FAIL watchdog: run did not end actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; asid_match_en = 1; cur_asid = 0; lookup_valid = 0; lookup_vpn = 0;
    fill_valid = 0; fill_vpn = 0; fill_pfn = 0; fill_asid = 0; fill_pin = 0; flush = 0;
    for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_pin[i] = 0; m_stamp[i] = 0; end
    repeat (5) @(negedge clk);
    check(lookup_done == 0 && fill_err == 0, "R1", "outputs in reset", lookup_done, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: idle outputs after reset
    check(lookup_done == 0, "R1", "lookup_done", lookup_done, 0);
    check(lookup_hit == 0,  "R1", "lookup_hit", lookup_hit, 0);
    check(refill_req == 0,  "R1", "refill_req", refill_req, 0);
    check(fill_err == 0,    "R1", "fill_err", fill_err, 0);
    check(lookup_pfn == 0,  "R1", "lookup_pfn", lookup_pfn, 0);
    look(20'h5, 8'h1, 1, "R1");

    // R5: fill into free entries, all remain
    for (int i = 0; i < N; i++) fill(20'h10 + i, 20'hA00 + i, 8'h1, 0, "R5");
    for (int i = 0; i < N; i++) look(20'h10 + i, 8'h1, 1, "R5");
    look(20'h99, 8'h1, 1, "R3");

    // R4: tag matching on and off
    look(20'h10, 8'h2, 1, "R4");
    look(20'h10, 8'h2, 0, "R4");

    // R6: replacement of the least recent unpinned entry
    fill(20'h20, 20'hB20, 8'h1, 0, "R6");
    look(20'h11, 8'h1, 1, "R6");
    look(20'h13, 8'h1, 1, "R6");
    look(20'h12, 8'h1, 1, "R6");
    fill(20'h21, 20'hB21, 8'h1, 0, "R6");
    fill(20'h22, 20'hB22, 8'h1, 0, "R6");
    for (int i = 0; i < N; i++) look(20'h10 + i, 8'h1, 1, "R6");
    for (int i = 0; i < 3; i++) look(20'h20 + i, 8'h1, 1, "R6");

    // R7: pinned entries survive heavy refill
    fill(20'h30, 20'hC30, 8'h1, 1, "R7");
    fill(20'h31, 20'hC31, 8'h1, 1, "R7");
    for (int i = 0; i < 12; i++) fill(20'h40 + i, 20'hD40 + i, 8'h1, 0, "R7");
    look(20'h30, 8'h1, 1, "R7");
    look(20'h31, 8'h1, 1, "R7");
    for (int i = 0; i < 12; i++) look(20'h40 + i, 8'h1, 1, "R7");

    // R10: lookup in the same cycle as a fill sees the old contents
    op(1, 20'h50, 8'h1, 1, 0, 1, 20'h50, 20'hE50, 8'h1, 0, "R10");
    look(20'h50, 8'h1, 1, "R10");

    // R10 and R8: lookup alongside a flush, then only pinned remain
    op(1, 20'h50, 8'h1, 1, 1, 0, 0, 0, 0, 0, "R10");
    look(20'h50, 8'h1, 1, "R8");
    look(20'h30, 8'h1, 1, "R8");
    look(20'h31, 8'h1, 1, "R8");
    for (int i = 6; i < 12; i++) look(20'h40 + i, 8'h1, 1, "R8");

    // R11: flush beats fill in the same cycle
    op(0, 0, 0, 1, 1, 1, 20'h60, 20'hF60, 8'h1, 0, "R11");
    look(20'h60, 8'h1, 1, "R11");

    // R9: every entry pinned, fill is dropped with a one-cycle error
    for (int i = 0; i < N - 2; i++) fill(20'h70 + i, 20'h770 + i, 8'h3, 1, "R9");
    fill(20'h80, 20'h880, 8'h3, 0, "R9");
    @(negedge clk);
    check(fill_err == 0, "R9", "fill_err second cycle", fill_err, 0);
    look(20'h80, 8'h3, 1, "R9");
    look(20'h70, 8'h3, 1, "R9");
    op(0, 0, 0, 1, 1, 0, 0, 0, 0, 0, "R8");
    look(20'h75, 8'h3, 1, "R8");
    look(20'h30, 8'h1, 1, "R7");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2", "pending results", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule